// File: doc/BRIEF.md
# Power State and Sink Enable Manager

This block decides whether a backlight driver is shut down, asleep or running. It looks at one thing to do that: how long the single control wire holds a level. A long high pulse wakes the device from shutdown into sleep. A long low level from any powered state shuts it down and asks the register file to return to defaults. Short low pulses, such as serial data bits, are ignored. A slow periodic tick, one pulse per millisecond, measures these durations.

Once the device is powered, the sink enable register selects the state. If any sink bit is set, the device runs, and the oscillator and charge pump are turned on. If every bit is clear, it drops back to sleep. Sleep still monitors the serial wire and leaves the regulators alone.

Two protection paths gate the sink enables that reach the current sinks:
- An over-temperature flag forces a thermal hold state. All outputs are off in this state, but the register contents are kept, so the sinks come back once the flag clears.
- A sink that reports an open circuit while it is driven is latched off. It stays off until its enable register is written again or the device shuts down.

Top module: `psm_power_mgr`

## Requirements
- R1: In shutdown, the synchronized wire must stay high without a break while more than EN_MS ticks arrive (default 2 ticks). After that the state becomes sleep. A high period that sees EN_MS ticks or fewer leaves the block in shutdown.
- R2: In any non-shutdown state, the synchronized wire may stay low without a break while more than DIS_MS ticks arrive (default 11 ticks). After that the state becomes shutdown. `reg_reset_o` is high during the whole of shutdown, and every sink output is 0 there.
- R3: `state_o` uses these codes: 2'b00 shutdown, 2'b01 sleep, 2'b10 running, 2'b11 thermal hold. After reset the state is shutdown, with `pump_en_o` low and `reg_reset_o` high.
- R4: In sleep or running, with no over-temperature, the state follows the enable register. Any set bit of `sink_en_i` gives running, and all bits clear gives sleep. `pump_en_o` is high only while running.
- R5: A low period on the wire that sees DIS_MS ticks or fewer changes neither the state nor the sink outputs.
- R6: While `otp_i` is high, a powered device holds thermal hold with all sink outputs 0 and `pump_en_o` low. When `otp_i` clears, the device returns through sleep to running, and the sinks come back with the enable bits they had before.
- R7: If `open_i[i]` is high while `sink_on_o[i]` is driven, sink i is latched off from the next cycle on.
- R8: A latched-off sink stays off until `en_wr_i` pulses (the enable register is rewritten) or until shutdown. Either event clears all latches.
- R9: `sink_on_o[i]` equals `sink_en_i[i]` AND NOT latched(i) while running, and is 0 otherwise. Bit 0 is sink 1 and bit 3 is sink 4. The enable bits are active high and default to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw level of the control wire (asynchronous) |
| tick_i | input | 1 | One-cycle pulse every millisecond |
| sink_en_i | input | N_SINK | Sink enable register bits |
| en_wr_i | input | 1 | One-cycle strobe when the enable register is written |
| otp_i | input | 1 | Over-temperature flag |
| open_i | input | N_SINK | Per-sink open-circuit flags |
| state_o | output | 2 | Power state code |
| pump_en_o | output | 1 | Oscillator and charge pump enable |
| reg_reset_o | output | 1 | Request to hold the register file at defaults |
| sink_on_o | output | N_SINK | Gated sink enables |

## Verification
A wrong duration count shows as the wrong `state_o` code. A miscount on the wake side shows within one tick of the expected transition. A miscount on the shutdown side shows within one tick and also changes `reg_reset_o`. A stuck float latch, or a latch that was not cleared, shows at once on the matching `sink_on_o` bit. It persists until the next register rewrite, so the bench samples that bit both before and after a rewrite. Thermal-hold errors show as nonzero sink outputs one cycle after `otp_i` rises. They also show as enable bits that differ after the flag clears.

// File: rtl/psm_pkg.sv
package psm_pkg;
  typedef enum logic [1:0] {
    PS_OFF   = 2'b00,
    PS_SLEEP = 2'b01,
    PS_RUN   = 2'b10,
    PS_HOT   = 2'b11
  } pwr_state_t;
endpackage

// File: rtl/psm_sync.sv
module psm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/psm_level_timer.sv
// Counts timebase ticks while the synchronized wire level stays constant.
module psm_level_timer #(
  parameter int EN_MS  = 1,
  parameter int DIS_MS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic tick_i,
  output logic hi_long_o,
  output logic lo_long_o
);
  localparam int CMAX = ((EN_MS > DIS_MS) ? EN_MS : DIS_MS) + 1;
  localparam int CW   = $clog2(CMAX + 1);

  logic          prev_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      if (lvl_i != prev_q)
        cnt_q <= '0;
      else if (tick_i && cnt_q != CW'(CMAX))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hi_long_o = prev_q  && (cnt_q > CW'(EN_MS));
  assign lo_long_o = !prev_q && (cnt_q > CW'(DIS_MS));
endmodule

// File: rtl/psm_float_guard.sv
// One sticky disable latch per sink, set by an open flag on a driven sink.
module psm_float_guard #(
  parameter int N_SINK = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [N_SINK-1:0] drive_i,
  input  logic [N_SINK-1:0] open_i,
  output logic [N_SINK-1:0] lat_o
);
  for (genvar g = 0; g < N_SINK; g++) begin : g_lat
    logic lat_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     lat_q <= 1'b0;
      else if (clr_i)                  lat_q <= 1'b0;
      else if (drive_i[g] && open_i[g]) lat_q <= 1'b1;
    end
    assign lat_o[g] = lat_q;
  end
endmodule

// File: rtl/psm_fsm.sv
module psm_fsm
  import psm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hi_long_i,
  input  logic       lo_long_i,
  input  logic       any_en_i,
  input  logic       otp_i,
  output pwr_state_t state_o
);
  pwr_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_OFF:   if (hi_long_i) st_d = PS_SLEEP;
      PS_SLEEP: begin
        if (lo_long_i)     st_d = PS_OFF;
        else if (otp_i)    st_d = PS_HOT;
        else if (any_en_i) st_d = PS_RUN;
      end
      PS_RUN: begin
        if (lo_long_i)      st_d = PS_OFF;
        else if (otp_i)     st_d = PS_HOT;
        else if (!any_en_i) st_d = PS_SLEEP;
      end
      PS_HOT: begin
        if (lo_long_i)   st_d = PS_OFF;
        else if (!otp_i) st_d = PS_SLEEP;
      end
      default: st_d = PS_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= PS_OFF;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/psm_power_mgr.sv
module psm_power_mgr
  import psm_pkg::*;
#(
  parameter int N_SINK      = 4,
  parameter int EN_MS       = 1,
  parameter int DIS_MS      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              tick_i,
  input  logic [N_SINK-1:0] sink_en_i,
  input  logic              en_wr_i,
  input  logic              otp_i,
  input  logic [N_SINK-1:0] open_i,
  output logic [1:0]        state_o,
  output logic              pump_en_o,
  output logic              reg_reset_o,
  output logic [N_SINK-1:0] sink_on_o
);
  logic              line_s;
  logic              hi_long, lo_long;
  logic [N_SINK-1:0] lat;
  pwr_state_t        state;

  psm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(line_s)
  );

  psm_level_timer #(.EN_MS(EN_MS), .DIS_MS(DIS_MS)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(line_s), .tick_i(tick_i),
    .hi_long_o(hi_long), .lo_long_o(lo_long)
  );

  psm_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .hi_long_i(hi_long), .lo_long_i(lo_long),
    .any_en_i(|sink_en_i), .otp_i(otp_i), .state_o(state)
  );

  psm_float_guard #(.N_SINK(N_SINK)) u_guard (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(en_wr_i || state == PS_OFF),
    .drive_i(sink_on_o), .open_i(open_i), .lat_o(lat)
  );

  assign sink_on_o   = (state == PS_RUN) ? (sink_en_i & ~lat) : '0;
  assign pump_en_o   = (state == PS_RUN);
  assign reg_reset_o = (state == PS_OFF);
  assign state_o     = state;
endmodule

// File: rtl/psm_power_mgr_chk.sv
module psm_power_mgr_chk #(
  parameter int N_SINK = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        state,
  input logic              hi_long,
  input logic              lo_long,
  input logic              otp,
  input logic              en_wr,
  input logic [N_SINK-1:0] sink_en,
  input logic [N_SINK-1:0] open_f,
  input logic [N_SINK-1:0] sink_on,
  input logic              pump_en
);
  // R1
  wake_needs_long_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b01 && $past(state) == 2'b00) |-> $past(hi_long));
  // R2
  off_needs_long_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b00 && $past(state) != 2'b00) |-> $past(lo_long));
  // R4
  run_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b10 && $past(state) != 2'b10) |-> $past(|sink_en));
  // R6
  hot_blanks_sinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(otp) |-> (sink_on == '0 && !pump_en));
  // R7
  float_stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sink_on & $past(sink_on & open_f)) != '0) |-> $past(en_wr));
endmodule

bind psm_power_mgr psm_power_mgr_chk #(.N_SINK(N_SINK)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .state(state_o), .hi_long(hi_long),
  .lo_long(lo_long), .otp(otp_i), .en_wr(en_wr_i), .sink_en(sink_en_i),
  .open_f(open_i), .sink_on(sink_on_o), .pump_en(pump_en_o)
);

// File: tb/psm_power_mgr_test.sv
`timescale 1ns/1ps
module psm_power_mgr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] sink_en = 4'h0;
  logic       en_wr = 1'b0;
  logic       otp = 1'b0;
  logic [3:0] open_f = 4'h0;
  logic [1:0] state;
  logic       pump_en, reg_reset;
  logic [3:0] sink_on;

  int total = 0;
  int bad = 0;
  logic [3:0] lat_m = 4'h0;

  always #5 clk = ~clk;

  int tcnt = 0;
  always @(posedge clk) begin
    tcnt <= (tcnt == 7) ? 0 : tcnt + 1;
    tick <= (tcnt == 7);
  end

  psm_power_mgr uut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .tick_i(tick),
    .sink_en_i(sink_en), .en_wr_i(en_wr), .otp_i(otp), .open_i(open_f),
    .state_o(state), .pump_en_o(pump_en), .reg_reset_o(reg_reset),
    .sink_on_o(sink_on)
  );

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_state(input logic [3:0] en);
    return (en != 4'h0) ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [3:0] exp_sinks(input logic [3:0] en, input logic [3:0] lt);
    return en & ~lt;
  endfunction

  task automatic write_en(input logic [3:0] v);
    sink_en = v; en_wr = 1'b1;
    cyc(1);
    en_wr = 1'b0;
    lat_m = 4'h0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R3 reset state
    chk("R3 state", state, 2'b00);
    chk("R3 reg_reset", reg_reset, 1'b1);
    chk("R3 pump", pump_en, 1'b0);
    // R1 short high does not wake
    line = 1'b1; cyc(6); line = 1'b0; cyc(20);
    chk("R1 short high", state, 2'b00);
    // R1 long high wakes
    line = 1'b1; cyc(60);
    chk("R1 wake", state, 2'b01);
    chk("R2 reg_reset released", reg_reset, 1'b0);
    chk("R4 sleep pump", pump_en, 1'b0);
    // R4 active
    write_en(4'b0101); cyc(3);
    chk("R4 run", state, 2'b10);
    chk("R4 pump", pump_en, 1'b1);
    chk("R9 sinks", sink_on, 4'b0101);

    // random mix
    void'($urandom(32'd4711));
    for (int it = 0; it < 40; it++) begin
      logic [3:0] v, o;
      int k;
      v = 4'($urandom_range(0, 15));
      write_en(v); cyc(2);
      if (($urandom % 2) == 0) begin
        o = 4'($urandom_range(0, 15));
        open_f = o; cyc(1); open_f = 4'h0;
        if (v != 4'h0) lat_m = lat_m | (o & v);
        cyc(2);
      end
      k = $urandom_range(1, 30);
      line = 1'b0; cyc(k); line = 1'b1; cyc(6);
      chk("R5/R4 rand state", state, exp_state(v));
      chk("R7/R9 rand sinks", sink_on, exp_sinks(v, lat_m));
      chk("R4 rand pump", pump_en, v != 4'h0);
    end

    // R5 near-limit low pulse
    write_en(4'b0011); cyc(2);
    line = 1'b0; cyc(70); line = 1'b1; cyc(6);
    chk("R5 long-short low state", state, 2'b10);
    chk("R5 long-short low sinks", sink_on, 4'b0011);

    // R6 thermal
    otp = 1'b1; cyc(3);
    chk("R6 hot state", state, 2'b11);
    chk("R6 hot sinks", sink_on, 4'h0);
    chk("R6 hot pump", pump_en, 1'b0);
    otp = 1'b0; cyc(4);
    chk("R6 recover state", state, 2'b10);
    chk("R6 recover sinks", sink_on, 4'b0011);

    // R7 / R8 float latch
    open_f = 4'b0001; cyc(1); open_f = 4'h0; cyc(2);
    chk("R7 float off", sink_on, 4'b0010);
    cyc(20);
    chk("R8 float held", sink_on, 4'b0010);
    write_en(4'b0011); cyc(2);
    chk("R8 rewrite clears", sink_on, 4'b0011);

    // R2 shutdown, latch again first
    open_f = 4'b0001; cyc(1); open_f = 4'h0; cyc(2);
    line = 1'b0; cyc(120);
    chk("R2 off state", state, 2'b00);
    chk("R2 reg_reset", reg_reset, 1'b1);
    chk("R2 off sinks", sink_on, 4'h0);
    sink_en = 4'h0;
    line = 1'b1; cyc(60);
    chk("R1 rewake", state, 2'b01);
    sink_en = 4'b0001; cyc(3);
    chk("R8 shutdown clears latch", sink_on, 4'b0001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule